// File: doc/BRIEF.md
# Mode Register Unlock Sequence Detector

This block sits inside a pseudo-static RAM model and watches a stream of already-decoded bus cycles. Each cycle is presented for one clock as a pulse on `cyc_valid`. The pulse carries four things: whether the cycle was a read or a write, its address, its data, and whether chip select and output enable toggled for that cycle. The block looks for a fixed four-cycle command that programs a small configuration register. That register holds a 2-bit partial-refresh density code and a page-length flag.

The command has four cycles, in this order:
1. A read of the top address (all ones).
2. A second read of the top address.
3. A write of zero to the top address.
4. A write to the top address of a setting word, which is accepted only in the range 0004h to 0007h.

Any deviation drops the attempt and leaves the register untouched. Reading the top address three times in a row locks the detector out. It stays locked until some other address is accessed. The register contents have no defined value at power-up, so a valid flag reports whether a setting has ever been accepted. Accesses to the top address are still ordinary memory accesses. This block only observes them.

Top module: `mode_unlock_det`

## Requirements
- R1: After reset `cfg_valid` is 0.
- R2: The sequence is: top read, top read, top write of data 0000h, top write of a setting word. When the setting word has bit 2 set and bits 15..3 clear, the clock edge that takes the fourth cycle loads `dens_q` with word bits 1..0 and `page8_q` with 1, and sets `cfg_valid`.
- R3: A cycle does not advance the sequence unless its chip-select toggle flag is set. A read cycle also needs its output-enable toggle flag set. A cycle missing either flag aborts the attempt.
- R4: A cycle to any address other than the top address (all ones) aborts the attempt.
- R5: A third cycle that writes nonzero data aborts the attempt.
- R6: A setting word with bit 2 clear, or with any of bits 15..3 set, is rejected and leaves the register unchanged.
- R7: Cycles of the wrong kind, such as a write where a read is due or a read where a write is due, abort the attempt.
- R8: A third consecutive read of the top address locks the detector. While locked, no sequence made only of top-address cycles can program the register.
- R9: Any cycle to another address leaves the locked state, and a following correct sequence then programs the register.
- R10: Once programmed, the register keeps its value through ordinary accesses and failed attempts until another sequence succeeds.
- R11: Clocks without `cyc_valid` change neither the sequence progress nor the register, so idle gaps between command cycles are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One-clock pulse marking a completed bus cycle |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_addr | input | ADDR_W (22) | Word address of the cycle |
| cyc_data | input | DATA_W (16) | Data written (ignored for reads) |
| cyc_cs_toggled | input | 1 | Chip select toggled for this cycle |
| cyc_oe_toggled | input | 1 | Output enable toggled for this cycle |
| dens_q | output | DENS_W (2) | Programmed partial-refresh density code |
| page8_q | output | 1 | Programmed page-length flag (1 = 8 words) |
| cfg_valid | output | 1 | Register has been programmed since reset |

## Verification
The bench targets the case where one top-address read too many arrives before the writes. A design that counted reads loosely would program the register instead of locking out. It also targets the locked state followed by a correct-looking top-only sequence. A design that left the lock on any write would accept that sequence. A missing output-enable toggle on the second read is tried as well. A detector that checked only chip select would take the update there. Setting words with reserved bits set or the page bit clear, and a zero-write that arrives out of order, show whether a design decodes the word and the order strictly or simply loads the final write.

// File: rtl/mode_unlock_det.sv
module mode_unlock_det #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int DENS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic              cyc_cs_toggled,
  input  logic              cyc_oe_toggled,
  output logic [DENS_W-1:0] dens_q,
  output logic              page8_q,
  output logic              cfg_valid
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam int PAGE_BIT = DENS_W;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_WR1, S_LOCK} seq_e;

  seq_e       st_q, st_d;
  logic [1:0] run_q, run_d;
  logic       prog;

  wire at_top   = cyc_addr == TOP_ADDR;
  wire rd_ok    = cyc_cs_toggled & cyc_oe_toggled;
  wire word_ok  = cyc_data[PAGE_BIT] & (cyc_data[DATA_W-1:PAGE_BIT+1] == '0);
  wire top_rd   = cyc_valid & at_top & ~cyc_write;
  wire top_wr   = cyc_valid & at_top & cyc_write;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    prog  = 1'b0;
    if (cyc_valid) begin
      if (!at_top) begin
        st_d  = S_IDLE;
        run_d = 2'd0;
      end else if (!cyc_write) begin
        if (run_q != 2'd3) run_d = run_q + 2'd1;
        if (run_q >= 2'd2) begin
          st_d = S_LOCK;
        end else begin
          unique case (st_q)
            S_IDLE:  st_d = rd_ok ? S_RD1 : S_IDLE;
            S_RD1:   st_d = rd_ok ? S_RD2 : S_IDLE;
            S_LOCK:  st_d = S_LOCK;
            default: st_d = S_IDLE;
          endcase
        end
      end else begin
        run_d = 2'd0;
        unique case (st_q)
          S_RD2:   st_d = (cyc_cs_toggled && cyc_data == '0) ? S_WR1 : S_IDLE;
          S_WR1: begin
            st_d = S_IDLE;
            prog = cyc_cs_toggled & word_ok;
          end
          S_LOCK:  st_d = S_LOCK;
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      run_q     <= 2'd0;
      cfg_valid <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      if (prog) cfg_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (prog) begin
      dens_q  <= cyc_data[DENS_W-1:0];
      page8_q <= cyc_data[PAGE_BIT];
    end
  end

  p_valid_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(top_wr));

  p_page_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> page8_q);

  p_bad_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && top_wr && !word_ok) |=> $stable({dens_q, page8_q}));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOCK && cyc_valid && at_top) |=> (st_q == S_LOCK && $stable({dens_q, page8_q})));

  p_third_read_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rd && run_q == 2'd2) |=> st_q == S_LOCK);

  p_other_addr_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !at_top) |=> st_q == S_IDLE);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cyc_valid) |=> ($stable({dens_q, page8_q, cfg_valid}) && $stable(st_q)));

endmodule

// File: tb/mode_unlock_det_tb_top.sv
`timescale 1ns/1ps
module mode_unlock_det_tb_top;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_valid = 1'b0;
  logic          cyc_write = 1'b0;
  logic [AW-1:0] cyc_addr = '0;
  logic [DW-1:0] cyc_data = '0;
  logic          cyc_cs_toggled = 1'b0;
  logic          cyc_oe_toggled = 1'b0;
  logic [1:0]    dens_q;
  logic          page8_q;
  logic          cfg_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_dens = 2'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mode_unlock_det dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_cs_toggled(cyc_cs_toggled),
    .cyc_oe_toggled(cyc_oe_toggled), .dens_q(dens_q), .page8_q(page8_q),
    .cfg_valid(cfg_valid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit cs, input bit oe);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_write = wr; cyc_addr = a; cyc_data = d;
    cyc_cs_toggled = cs; cyc_oe_toggled = oe;
    @(negedge clk);
    cyc_valid = 1'b0; cyc_cs_toggled = 1'b0; cyc_oe_toggled = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a); bus(1'b0, a, 16'h0, 1'b1, 1'b1); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d); bus(1'b1, a, d, 1'b1, 1'b0); endtask
  task automatic clear_hist(); rd(22'h000123); endtask

  task automatic unlock(input logic [DW-1:0] word);
    rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, word);
  endtask

  task automatic expect_reg(input string req);
    check(cfg_valid === 1'b1, req, cfg_valid, 1);
    check(dens_q === exp_dens, req, dens_q, exp_dens);
    check(page8_q === 1'b1, req, page8_q, 1);
  endtask

  task automatic t_reset();
    check(cfg_valid === 1'b0, "R1", cfg_valid, 0);
  endtask

  task automatic t_program();
    clear_hist();
    unlock(16'h0006); exp_dens = 2'd2;
    expect_reg("R2");
    clear_hist();
    rd(TOP); repeat (3) @(negedge clk);
    rd(TOP); repeat (2) @(negedge clk);
    wr(TOP, 16'h0000); repeat (4) @(negedge clk);
    wr(TOP, 16'h0005); exp_dens = 2'd1;
    expect_reg("R11");
  endtask

  task automatic t_toggles();
    clear_hist();
    rd(TOP); bus(1'b0, TOP, 16'h0, 1'b1, 1'b0); wr(TOP, 16'h0000); wr(TOP, 16'h0007);
    expect_reg("R3");
    clear_hist();
    rd(TOP); rd(TOP); wr(TOP, 16'h0000); bus(1'b1, TOP, 16'h0004, 1'b0, 1'b0);
    expect_reg("R3");
  endtask

  task automatic t_wrong_addr();
    clear_hist();
    rd(TOP); rd(TOP); wr(TOP - 1, 16'h0000); wr(TOP, 16'h0006);
    expect_reg("R4");
  endtask

  task automatic t_wrong_data();
    clear_hist();
    rd(TOP); rd(TOP); wr(TOP, 16'h0001); wr(TOP, 16'h0006);
    expect_reg("R5");
  endtask

  task automatic t_bad_word();
    clear_hist(); unlock(16'h000C); expect_reg("R6");
    clear_hist(); unlock(16'h0003); expect_reg("R6");
    clear_hist(); unlock(16'h8004); expect_reg("R6");
  endtask

  task automatic t_order();
    clear_hist();
    wr(TOP, 16'h0000); rd(TOP); rd(TOP); wr(TOP, 16'h0007);
    expect_reg("R7");
    clear_hist();
    rd(TOP); rd(TOP); wr(TOP, 16'h0000); rd(TOP); wr(TOP, 16'h0007);
    expect_reg("R7");
    wr(TOP, 16'h1234); rd(TOP);
    expect_reg("R10");
  endtask

  task automatic t_lock();
    clear_hist();
    rd(TOP); rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'h0004);
    expect_reg("R8");
    unlock(16'h0004);
    expect_reg("R8");
    rd(22'h00ABCD);
    unlock(16'h0004); exp_dens = 2'd0;
    expect_reg("R9");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_toggles();
    t_wrong_addr();
    t_wrong_data();
    t_bad_word();
    t_order();
    t_lock();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule